// File: doc/BRIEF.md
# Configurable Base Address Decoder

This block holds a device's base address registers in a small configuration-space register file: a row of general slots, each of which can be a 32-bit memory window, a 64-bit memory window spread across two neighbouring slots, an I/O window or unused, plus one expansion ROM base register. The kind, size and prefetch flag of each slot are fixed by parameters. Only the address bits above the window's size can be written, so writing all ones and reading back reveals the size as a naturally aligned power of two. The fixed low bits report the window's type.

In parallel, the block compares a bus address and its memory/I-O qualifier against every programmed base and raises one hit flag per slot, plus one for the ROM. Configuration reads are combinational on the selected index; writes take effect at the next clock edge.

Top module: `bar_decoder`

## Requirements
- R1: After reset every writable base bit is zero, so each slot reads back only its fixed type bits and the ROM register reads zero.
- R2: Fixed low bits are read-only: bit 0 is 0 for memory and 1 for I/O; memory bits 2:1 are 00 for a 32-bit window and 10 for a 64-bit window; memory bit 3 is the prefetch flag; I/O bit 1 is 0.
- R3: After all ones are written, a slot reads ones in every bit at and above its size boundary, zero below it apart from the type bits; a prefetchable 1 MB 32-bit memory slot reads 0xFFF00008.
- R4: A configured size is limited to at least 16 bytes for memory and between 4 and 256 bytes for I/O; with defaults slot 5 (asked for 4 bytes) probes as 0xFFFFFFF0 and slot 1 (asked for 1 KB) probes as 0xFFFFFF01.
- R5: The slot above a 64-bit memory slot holds address bits 63:32, is fully writable, and the hit for the pair is raised on the lower slot only when address bits 63:32 equal it.
- R6: Writes update only the bytes whose enable bit is set; a write with no enables leaves the register unchanged.
- R7: A write changes only the register selected by the index; unused slots and indices above the ROM read zero and ignore writes.
- R8: A memory slot hits when the qualifier says memory and the address bits at and above its size boundary equal its base; for a 32-bit slot, address bits 63:32 must be zero.
- R9: An I/O slot hits only when the qualifier says I/O, address bits 63:32 are zero and the bits above its size boundary match; a memory slot never hits on an I/O access.
- R10: The ROM register sits at index equal to the slot count (6 by default); bit 0 is a writable decode enable, bits 10:1 read zero, the base is at least 2 KB aligned, and the ROM hits on a memory access only while enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_idx | input | IDX_W | Register index; 0..NUM_SLOTS-1 slots, NUM_SLOTS the ROM register |
| cfg_wr | input | 1 | Write strobe for the selected register |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_rdata | output | 32 | Read value of the selected register |
| dec_addr | input | 64 | Address to decode |
| dec_is_io | input | 1 | 1 for an I/O access, 0 for memory |
| dec_hit | output | NUM_SLOTS+1 | Per-slot hit flags, top bit for the ROM |

## Verification
On every cycle the assertions check that a register holds its value without a write or with all byte enables clear, that an all-ones write produces the size-probe pattern, that a hit never contradicts the memory/I-O qualifier, that a 32-bit window never hits with upper address bits set, and that the ROM hits only while enabled. The exact probe values per slot kind, size clamping, byte-lane merging, the pairing of a 64-bit window with its upper slot, isolation between indices and hit/miss at window edges rest on the bench's scenarios, which compare read data and the full hit vector against values worked out from the requirements.

// File: rtl/bar_decode_pkg.sv
package bar_decode_pkg;

    typedef logic [31:0] cfg_word_t;

    localparam int KIND_NONE    = 0;
    localparam int KIND_MEM32   = 1;
    localparam int KIND_MEM64   = 2;
    localparam int KIND_MEM64HI = 3;
    localparam int KIND_IO      = 4;
    localparam int KIND_ROM     = 5;

    // Clamp a requested log2 size to the legal range for the kind.
    function automatic int eff_log2(input int kind, input int req);
        int r;
        r = req;
        case (kind)
            KIND_MEM32, KIND_MEM64: begin
                if (r < 4)  r = 4;
                if (r > 31) r = 31;
            end
            KIND_IO: begin
                if (r < 2) r = 2;
                if (r > 8) r = 8;
            end
            KIND_ROM: begin
                if (r < 11) r = 11;
                if (r > 31) r = 31;
            end
            default: r = 0;
        endcase
        return r;
    endfunction

    // Bits software may change.
    function automatic cfg_word_t slot_wmask(input int kind, input int req);
        cfg_word_t low;
        low = (32'h1 << eff_log2(kind, req)) - 32'h1;
        case (kind)
            KIND_MEM32, KIND_MEM64, KIND_IO: return ~low;
            KIND_MEM64HI:                    return 32'hFFFF_FFFF;
            KIND_ROM:                        return ~low | 32'h1;
            default:                         return 32'h0;
        endcase
    endfunction

    // Read-only type bits.
    function automatic cfg_word_t slot_fixed(input int kind, input logic pref);
        case (kind)
            KIND_MEM32: return {28'h0, pref, 3'b000};
            KIND_MEM64: return {28'h0, pref, 3'b100};
            KIND_IO:    return 32'h1;
            default:    return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/bar_slot.sv
module bar_slot
    import bar_decode_pkg::*;
#(
    parameter cfg_word_t WMASK = 32'h0,
    parameter cfg_word_t FIXED = 32'h0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  cfg_word_t wdata,
    input  logic [3:0] be,
    output cfg_word_t rd_val,
    output cfg_word_t base
);

    typedef struct packed {
        cfg_word_t store;
    } slot_state_t;

    slot_state_t st_d, st_q;
    cfg_word_t   lane_m;

    always_comb begin
        for (int b = 0; b < 4; b++) begin
            lane_m[b*8 +: 8] = {8{be[b]}};
        end
        st_d = st_q;
        if (wr_en) begin
            st_d.store = (st_q.store & ~(lane_m & WMASK)) | (wdata & lane_m & WMASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base   = st_q.store & WMASK;
    assign rd_val = base | FIXED;

    assert_hold_without_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_val));

    assert_no_lane_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && be == 4'h0) |=> $stable(rd_val));

    assert_probe_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && be == 4'hF && wdata == 32'hFFFF_FFFF) |=> (rd_val == (WMASK | FIXED)));

endmodule

// File: rtl/bar_match.sv
module bar_match
    import bar_decode_pkg::*;
#(
    parameter int        KIND  = KIND_NONE,
    parameter cfg_word_t WMASK = 32'h0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic [63:0] addr,
    input  logic      is_io,
    input  cfg_word_t base_lo,
    input  cfg_word_t base_hi,
    output logic      hit
);

    localparam cfg_word_t CMP_MASK = (KIND == KIND_ROM) ? (WMASK & ~32'h1) : WMASK;

    logic lo_ok;
    logic hi_zero;

    always_comb begin
        lo_ok   = ((addr[31:0] & CMP_MASK) == (base_lo & CMP_MASK));
        hi_zero = (addr[63:32] == 32'h0);
        case (KIND)
            KIND_MEM32: hit = !is_io && hi_zero && lo_ok;
            KIND_MEM64: hit = !is_io && (addr[63:32] == base_hi) && lo_ok;
            KIND_IO:    hit = is_io && hi_zero && lo_ok;
            KIND_ROM:   hit = !is_io && base_lo[0] && hi_zero && lo_ok;
            default:    hit = 1'b0;
        endcase
    end

    assert_io_qualifier_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (is_io == (KIND == KIND_IO)));

    assert_mem32_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && KIND == KIND_MEM32) |-> (addr[63:32] == 32'h0));

    assert_rom_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && KIND == KIND_ROM) |-> base_lo[0]);

endmodule

// File: rtl/bar_decoder.sv
module bar_decoder
    import bar_decode_pkg::*;
#(
    parameter int NUM_SLOTS = 6,
    parameter logic [NUM_SLOTS*3-1:0] SLOT_KINDS = {3'd1, 3'd0, 3'd3, 3'd2, 3'd4, 3'd1},
    parameter logic [NUM_SLOTS*5-1:0] SLOT_SIZES = {5'd2, 5'd0, 5'd0, 5'd12, 5'd10, 5'd20},
    parameter logic [NUM_SLOTS-1:0]   SLOT_PREF  = 6'b000001,
    parameter int ROM_SIZE_LOG2 = 16,
    localparam int NUM_REGS = NUM_SLOTS + 1,
    localparam int IDX_W    = $clog2(NUM_REGS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic                 cfg_wr,
    input  logic [31:0]          cfg_wdata,
    input  logic [3:0]           cfg_be,
    output logic [31:0]          cfg_rdata,
    input  logic [63:0]          dec_addr,
    input  logic                 dec_is_io,
    output logic [NUM_SLOTS:0]   dec_hit
);

    cfg_word_t reg_rd   [NUM_REGS];
    cfg_word_t reg_base [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam int KIND = (i == NUM_SLOTS) ? KIND_ROM : int'(SLOT_KINDS[i*3 +: 3]);
        localparam int SZ   = (i == NUM_SLOTS) ? ROM_SIZE_LOG2 : int'(SLOT_SIZES[i*5 +: 5]);
        localparam logic PF = (i == NUM_SLOTS) ? 1'b0 : SLOT_PREF[i];
        localparam cfg_word_t WM = slot_wmask(KIND, SZ);
        localparam cfg_word_t FX = slot_fixed(KIND, PF);

        logic      sel_wr;
        cfg_word_t upper;

        assign sel_wr = cfg_wr && (int'(cfg_idx) == i);

        bar_slot #(.WMASK(WM), .FIXED(FX)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (sel_wr),
            .wdata  (cfg_wdata),
            .be     (cfg_be),
            .rd_val (reg_rd[i]),
            .base   (reg_base[i])
        );

        if (i + 1 < NUM_SLOTS) begin : g_up
            assign upper = reg_base[i+1];
        end else begin : g_noup
            assign upper = 32'h0;
        end

        bar_match #(.KIND(KIND), .WMASK(WM)) u_match (
            .clk     (clk),
            .rst_n   (rst_n),
            .addr    (dec_addr),
            .is_io   (dec_is_io),
            .base_lo (reg_base[i]),
            .base_hi (upper),
            .hit     (dec_hit[i])
        );
    end

    always_comb begin
        cfg_rdata = 32'h0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (int'(cfg_idx) == i) cfg_rdata = reg_rd[i];
        end
    end

endmodule

// File: tb/bar_decoder_tb_top.sv
module bar_decoder_tb_top;

    typedef struct {
        bit          is_hit;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_rdata;
    logic [63:0] dec_addr = '0;
    logic        dec_is_io = 1'b0;
    logic [6:0]  dec_hit;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    sb_item_t sb_q[$];

    always #10 clk = ~clk;

    bar_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_idx(cfg_idx), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata),
        .dec_addr(dec_addr), .dec_is_io(dec_is_io), .dec_hit(dec_hit)
    );

    // Monitor: compares queued expectations away from the rising edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            sb_item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            act = it.is_hit ? {25'h0, dec_hit} : cfg_rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input int idx, input logic [31:0] d, input logic [3:0] be);
        cfg_idx = 3'(idx); cfg_wdata = d; cfg_be = be; cfg_wr = 1'b1;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input int idx, input logic [31:0] exp, input string tag);
        sb_item_t it;
        cfg_idx = 3'(idx);
        it.is_hit = 1'b0; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic probe_hit(input logic [63:0] a, input logic io,
                             input logic [6:0] exp, input string tag);
        sb_item_t it;
        dec_addr = a; dec_is_io = io;
        it.is_hit = 1'b1; it.exp = {25'h0, exp}; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 / R2: reset values show only the type bits
        rd(0, 32'h0000_0008, "R1 R2 slot0 reset mem32 prefetch");
        rd(1, 32'h0000_0001, "R1 R2 slot1 reset io");
        rd(2, 32'h0000_0004, "R1 R2 slot2 reset mem64");
        rd(3, 32'h0000_0000, "R1 slot3 reset upper");
        rd(6, 32'h0000_0000, "R1 rom reset");

        // R3 / R4 / R10: size probe
        wr(0, 32'hFFFF_FFFF, 4'hF); rd(0, 32'hFFF0_0008, "R3 slot0 probe 1MB");
        wr(1, 32'hFFFF_FFFF, 4'hF); rd(1, 32'hFFFF_FF01, "R4 slot1 io clamp 256B");
        wr(2, 32'hFFFF_FFFF, 4'hF); rd(2, 32'hFFFF_F004, "R3 slot2 probe 4KB mem64");
        wr(3, 32'hFFFF_FFFF, 4'hF); rd(3, 32'hFFFF_FFFF, "R5 slot3 upper fully writable");
        wr(5, 32'hFFFF_FFFF, 4'hF); rd(5, 32'hFFFF_FFF0, "R4 slot5 clamp 16B");
        wr(6, 32'hFFFF_FFFF, 4'hF); rd(6, 32'hFFFF_0001, "R10 rom probe");

        // R2: type bits ignore written zeros
        wr(1, 32'h0000_0000, 4'hF); rd(1, 32'h0000_0001, "R2 io bit0 read-only");

        // program bases
        wr(0, 32'h1234_5678, 4'hF); rd(0, 32'h1230_0008, "R3 slot0 base");
        wr(1, 32'h0000_C0FF, 4'hF); rd(1, 32'h0000_C001, "R9 slot1 base");
        wr(2, 32'hABCD_E123, 4'hF); rd(2, 32'hABCD_E004, "R5 slot2 base");
        wr(3, 32'h0000_0001, 4'hF); rd(3, 32'h0000_0001, "R5 slot3 upper");
        wr(5, 32'h4000_001F, 4'hF); rd(5, 32'h4000_0010, "R4 slot5 base");

        // R6: byte lanes
        wr(0, 32'hFFFF_FFFF, 4'b1000); rd(0, 32'hFF30_0008, "R6 top lane only");
        wr(0, 32'h0000_0000, 4'b0000); rd(0, 32'hFF30_0008, "R6 no lanes");
        wr(0, 32'h1234_5678, 4'hF);    rd(0, 32'h1230_0008, "R6 restore");
        wr(3, 32'hAABB_CCDD, 4'b0101); rd(3, 32'h00BB_00DD, "R6 lanes 0 and 2");
        wr(3, 32'h0000_0001, 4'hF);    rd(3, 32'h0000_0001, "R6 restore upper");

        // R7: isolation
        wr(4, 32'hFFFF_FFFF, 4'hF); rd(4, 32'h0000_0000, "R7 unused slot");
        wr(7, 32'hFFFF_FFFF, 4'hF); rd(7, 32'h0000_0000, "R7 index beyond rom");
        rd(0, 32'h1230_0008, "R7 slot0 untouched");
        rd(5, 32'h4000_0010, "R7 slot5 untouched");

        // R8 / R9 / R5 hits
        probe_hit(64'h0000_0000_123F_FFFC, 1'b0, 7'b0000001, "R8 slot0 top of window");
        probe_hit(64'h0000_0000_1230_0000, 1'b0, 7'b0000001, "R8 slot0 bottom of window");
        probe_hit(64'h0000_0000_1240_0000, 1'b0, 7'b0000000, "R8 slot0 above window");
        probe_hit(64'h0000_0001_1230_0000, 1'b0, 7'b0000000, "R8 mem32 upper bits set");
        probe_hit(64'h0000_0000_1230_0000, 1'b1, 7'b0000000, "R9 mem slot ignores io");
        probe_hit(64'h0000_0000_0000_C0A0, 1'b1, 7'b0000010, "R9 io hit");
        probe_hit(64'h0000_0000_0000_C100, 1'b1, 7'b0000000, "R9 io beyond 256B");
        probe_hit(64'h0000_0000_0000_C0A0, 1'b0, 7'b0000000, "R9 io slot ignores mem");
        probe_hit(64'h0000_0001_ABCD_E7F0, 1'b0, 7'b0000100, "R5 mem64 hit");
        probe_hit(64'h0000_0000_ABCD_E7F0, 1'b0, 7'b0000000, "R5 mem64 wrong upper");
        probe_hit(64'h0000_0000_4000_001C, 1'b0, 7'b0100000, "R4 16B window hit");
        probe_hit(64'h0000_0000_4000_0020, 1'b0, 7'b0000000, "R4 16B window miss");

        // R10: rom enable
        wr(6, 32'h0005_0000, 4'hF); rd(6, 32'h0005_0000, "R10 rom base disabled");
        probe_hit(64'h0000_0000_0005_ABCD, 1'b0, 7'b0000000, "R10 rom disabled no hit");
        wr(6, 32'h0005_07FF, 4'hF); rd(6, 32'h0005_0001, "R10 reserved bits zero");
        probe_hit(64'h0000_0000_0005_ABCD, 1'b0, 7'b1000000, "R10 rom enabled hit");
        probe_hit(64'h0000_0000_0005_ABCD, 1'b1, 7'b0000000, "R10 rom ignores io");
        probe_hit(64'h0000_0000_0006_0000, 1'b0, 7'b0000000, "R10 rom above window");

        @(posedge clk); #1;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule